// File: doc/BRIEF.md
# Checkered-Layout Binary Fully-Connected Classifier

This block is the final scoring stage of a small binary network. It takes a plane of pooled, non-negative activations and a plane of one-bit weights, one weight per element. A weight bit of 1 keeps the activation and a bit of 0 negates it. Each 2×2 group of elements holds weights for four different output labels, one label per position. The products that belong to one label therefore form a checkered pattern across the plane.

After a start pulse, the block captures both planes. It then runs four passes through one shared adder tree. Each pass masks the plane down to one label's positions and sums the signed products into that label's score. After the fourth pass, an argmax picks the label with the largest score. The four signed scores and the winning label index are published together with a one-cycle done pulse. They hold until the next result is published.

Top module: `fcc_checker_classifier`

## Requirements
- R1: Element e's activation is counted as +a when weight bit e is 1 and as −a when it is 0.
- R2: Element e sits at row r = e / COLS and column c = e mod COLS. Its label is 2·(r mod 2) + (c mod 2). Label k's score is the signed sum over its own elements only, and appears at `label_sums[k*SUM_W +: SUM_W]`.
- R3: `class_idx` is the label with the largest score. When scores are equal, the lowest label index wins.
- R4: A start that is sampled while idle produces exactly one result. `done` is high for one cycle, right after the fifth rising edge that follows the accepting edge.
- R5: A start sampled while busy is ignored. Changes to the input planes after the accepting edge do not affect that result.
- R6: After reset, `busy`, `done`, all scores and `class_idx` are zero. Scores and class change only on the edge that raises `done`, and hold otherwise.
- R7: Scores are two's complement, SUM_W = ACT_W + log2(ROWS·COLS/4) + 1 bits wide. They are exact at the extremes: every activation at its maximum with all weights +1, or with all weights −1.
- R8: `busy` is high from the accepting edge up to and including the `done` cycle. It is low after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a classification; accepted only while idle |
| act_plane | input | ROWS*COLS*ACT_W | Unsigned activations; element e at bits [e*ACT_W +: ACT_W] |
| wgt_plane | input | ROWS*COLS | Weight bits; bit e = 1 means +1, 0 means −1 |
| busy | output | 1 | A classification is in progress |
| done | output | 1 | One-cycle pulse: scores and class just updated |
| label_sums | output | 4*SUM_W | Signed label scores, label k at [k*SUM_W +: SUM_W] |
| class_idx | output | 2 | Winning label |

Control states: ST_IDLE goes to ST_ACCUM on start. ST_ACCUM runs four passes, one label each, then goes to ST_SELECT. ST_SELECT goes to ST_FINISH, which pulses done. ST_FINISH returns to ST_IDLE.

## Verification
A wrong pass counter or mask shows up in the same result: one label's score carries another label's elements, so its value is wrong at the next done. A wrong state sequence moves or repeats the done pulse, which shows within six cycles of start. An argmax fault, including a wrong tie rule, shows at class_idx on the same done cycle. Input planes that are not properly captured show when the planes are scrambled right after start.

// File: rtl/fcc_pkg.sv
`timescale 1ns/1ps
package fcc_pkg;
    localparam int NUM_LABELS = 4;
    localparam int LABEL_W    = 2;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ACCUM  = 2'd1,
        ST_SELECT = 2'd2,
        ST_FINISH = 2'd3
    } fcc_state_e;

    // Label owned by position (r, c): row parity is the high bit, column parity the low bit.
    function automatic logic [LABEL_W-1:0] label_of(input int r, input int c);
        return {r[0], c[0]};
    endfunction
endpackage

// File: rtl/fcc_signed_mask.sv
`timescale 1ns/1ps
module fcc_signed_mask #(
    parameter int ROWS  = 8,
    parameter int COLS  = 8,
    parameter int ACT_W = 8,
    parameter int SUM_W = 13
) (
    input  logic [ROWS*COLS*ACT_W-1:0] act_plane,
    input  logic [ROWS*COLS-1:0]       wgt_plane,
    input  logic [1:0]                 sel_label,
    output logic [ROWS*COLS*SUM_W-1:0] terms
);
    localparam int PAD_W = SUM_W - ACT_W;

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        for (genvar c = 0; c < COLS; c++) begin : g_col
            localparam int          ELEM = r * COLS + c;
            localparam logic [1:0]  LAB  = fcc_pkg::label_of(r, c);
            logic signed [SUM_W-1:0] mag;
            logic signed [SUM_W-1:0] prod;

            assign mag  = {{PAD_W{1'b0}}, act_plane[ELEM*ACT_W +: ACT_W]};
            assign prod = wgt_plane[ELEM] ? mag : -mag;
            assign terms[ELEM*SUM_W +: SUM_W] = (sel_label == LAB) ? prod : '0;
        end
    end
endmodule

// File: rtl/fcc_adder_tree.sv
`timescale 1ns/1ps
module fcc_adder_tree #(
    parameter int N_IN  = 64,
    parameter int SUM_W = 13
) (
    input  logic [N_IN*SUM_W-1:0] terms,
    output logic [SUM_W-1:0]      total
);
    localparam int LEVELS = (N_IN > 1) ? $clog2(N_IN) : 1;
    localparam int LEAVES = 1 << LEVELS;

    for (genvar l = 0; l <= LEVELS; l++) begin : g_lvl
        localparam int WIDTH = LEAVES >> l;
        logic [SUM_W-1:0] v [WIDTH];
        if (l == 0) begin : g_leaf
            for (genvar i = 0; i < WIDTH; i++) begin : g_in
                if (i < N_IN) begin : g_real
                    assign v[i] = terms[i*SUM_W +: SUM_W];
                end else begin : g_pad
                    assign v[i] = '0;
                end
            end
        end else begin : g_node
            for (genvar i = 0; i < WIDTH; i++) begin : g_add
                assign v[i] = g_lvl[l-1].v[2*i] + g_lvl[l-1].v[2*i+1];
            end
        end
    end

    assign total = g_lvl[LEVELS].v[0];
endmodule

// File: rtl/fcc_argmax.sv
`timescale 1ns/1ps
module fcc_argmax #(
    parameter int SUM_W = 13
) (
    input  logic [fcc_pkg::NUM_LABELS*SUM_W-1:0] sums,
    output logic [1:0]                           winner
);
    logic signed [SUM_W-1:0] best;

    always_comb begin
        winner = 2'd0;
        best   = $signed(sums[0 +: SUM_W]);
        for (int k = 1; k < fcc_pkg::NUM_LABELS; k++) begin
            // strict compare keeps the lower index on ties
            if ($signed(sums[k*SUM_W +: SUM_W]) > best) begin
                best   = $signed(sums[k*SUM_W +: SUM_W]);
                winner = 2'(k);
            end
        end
    end
endmodule

// File: rtl/fcc_ctrl.sv
`timescale 1ns/1ps
module fcc_ctrl (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    output logic       capture_en,
    output logic       acc_en,
    output logic [1:0] pass_idx,
    output logic       select_en,
    output logic       busy,
    output logic       done
);
    import fcc_pkg::*;

    localparam logic [1:0] LAST_PASS = 2'(NUM_LABELS - 1);

    fcc_state_e state_q, state_d;
    logic [1:0] pass_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  pass_q <= '0;
        else if (state_q == ST_ACCUM) pass_q <= pass_q + 2'd1;
        else                         pass_q <= '0;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start) state_d = ST_ACCUM;
            ST_ACCUM:  if (pass_q == LAST_PASS) state_d = ST_SELECT;
            ST_SELECT: state_d = ST_FINISH;
            ST_FINISH: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        capture_en = 1'b0;
        acc_en     = 1'b0;
        select_en  = 1'b0;
        busy       = 1'b1;
        done       = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                busy       = 1'b0;
                capture_en = start;
            end
            ST_ACCUM:  acc_en    = 1'b1;
            ST_SELECT: select_en = 1'b1;
            ST_FINISH: done      = 1'b1;
        endcase
    end

    assign pass_idx = pass_q;
endmodule

// File: rtl/fcc_checker_classifier.sv
`timescale 1ns/1ps
module fcc_checker_classifier #(
    parameter int ROWS  = 8,
    parameter int COLS  = 8,
    parameter int ACT_W = 8,
    localparam int N_ELEM = ROWS * COLS,
    localparam int SUM_W  = ACT_W + $clog2(N_ELEM / 4) + 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start,
    input  logic [N_ELEM*ACT_W-1:0]   act_plane,
    input  logic [N_ELEM-1:0]         wgt_plane,
    output logic                      busy,
    output logic                      done,
    output logic [4*SUM_W-1:0]        label_sums,
    output logic [1:0]                class_idx
);
    import fcc_pkg::*;

    logic             capture_en, acc_en, select_en;
    logic [1:0]       pass_idx;
    logic [N_ELEM*ACT_W-1:0] act_q;
    logic [N_ELEM-1:0]       wgt_q;
    logic [N_ELEM*SUM_W-1:0] terms;
    logic [SUM_W-1:0]        pass_total;
    logic [NUM_LABELS*SUM_W-1:0] work_sums;
    logic [1:0]              winner;

    fcc_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .capture_en (capture_en),
        .acc_en     (acc_en),
        .pass_idx   (pass_idx),
        .select_en  (select_en),
        .busy       (busy),
        .done       (done)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_q <= '0;
            wgt_q <= '0;
        end else if (capture_en) begin
            act_q <= act_plane;
            wgt_q <= wgt_plane;
        end
    end

    fcc_signed_mask #(
        .ROWS(ROWS), .COLS(COLS), .ACT_W(ACT_W), .SUM_W(SUM_W)
    ) u_mask (
        .act_plane (act_q),
        .wgt_plane (wgt_q),
        .sel_label (pass_idx),
        .terms     (terms)
    );

    fcc_adder_tree #(.N_IN(N_ELEM), .SUM_W(SUM_W)) u_tree (
        .terms (terms),
        .total (pass_total)
    );

    for (genvar k = 0; k < NUM_LABELS; k++) begin : g_work
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                work_sums[k*SUM_W +: SUM_W] <= '0;
            else if (acc_en && pass_idx == 2'(k))
                work_sums[k*SUM_W +: SUM_W] <= pass_total;
        end
    end

    fcc_argmax #(.SUM_W(SUM_W)) u_argmax (
        .sums   (work_sums),
        .winner (winner)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            label_sums <= '0;
            class_idx  <= '0;
        end else if (select_en) begin
            label_sums <= work_sums;
            class_idx  <= winner;
        end
    end
endmodule

// File: rtl/fcc_checker_classifier_chk.sv
`timescale 1ns/1ps
module fcc_checker_classifier_chk #(
    parameter int ROWS  = 8,
    parameter int COLS  = 8,
    parameter int ACT_W = 8,
    parameter int SUM_W = 13
) (
    input logic               clk,
    input logic               rst_n,
    input logic               start,
    input logic               busy,
    input logic               done,
    input logic [4*SUM_W-1:0] label_sums,
    input logic [1:0]         class_idx
);
    localparam int BOUND = (ROWS * COLS / 4) * ((1 << ACT_W) - 1);

    logic [3:0] lat_cnt;
    logic       argmax_ok;
    logic       range_ok;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              lat_cnt <= '0;
        else if (start && !busy) lat_cnt <= 4'd1;
        else if (busy)           lat_cnt <= lat_cnt + 4'd1;
    end

    always_comb begin
        logic signed [SUM_W-1:0] top;
        logic signed [SUM_W-1:0] s;
        top       = $signed(label_sums[class_idx*SUM_W +: SUM_W]);
        argmax_ok = 1'b1;
        range_ok  = 1'b1;
        for (int k = 0; k < 4; k++) begin
            s = $signed(label_sums[k*SUM_W +: SUM_W]);
            if (s > top) argmax_ok = 1'b0;
            if (k < int'(class_idx) && s == top) argmax_ok = 1'b0;
            if (int'(s) > BOUND || int'(s) < -BOUND) range_ok = 1'b0;
        end
    end

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R4
    AST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (lat_cnt == 4'd6)); // R4
    AST_BUSY_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy); // R8
    AST_BUSY_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy); // R8
    AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable({label_sums, class_idx}) |-> done); // R6
    AST_ARGMAX: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> argmax_ok); // R3
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> range_ok); // R7
endmodule

bind fcc_checker_classifier fcc_checker_classifier_chk #(
    .ROWS(ROWS), .COLS(COLS), .ACT_W(ACT_W), .SUM_W(SUM_W)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .busy       (busy),
    .done       (done),
    .label_sums (label_sums),
    .class_idx  (class_idx)
);

// File: tb/fcc_checker_classifier_tb_top.sv
`timescale 1ns/1ps
module fcc_checker_classifier_tb_top;
    localparam int ROWS  = 8;
    localparam int COLS  = 8;
    localparam int ACT_W = 8;
    localparam int N     = ROWS * COLS;
    localparam int SUM_W = ACT_W + $clog2(N / 4) + 1;
    localparam int AMAX  = (1 << ACT_W) - 1;

    typedef struct packed {
        logic [3:0][31:0] sums;
        logic [1:0]       cls;
        logic [31:0]      due;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [N*ACT_W-1:0] act_plane = '0;
    logic [N-1:0]       wgt_plane = '0;
    logic busy, done;
    logic [4*SUM_W-1:0] label_sums;
    logic [1:0] class_idx;

    logic [N*ACT_W-1:0] act_v;
    logic [N-1:0]       wgt_v;
    exp_t  sb_q[$];
    string tag_q[$];
    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    fcc_checker_classifier #(.ROWS(ROWS), .COLS(COLS), .ACT_W(ACT_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start),
        .act_plane(act_plane), .wgt_plane(wgt_plane),
        .busy(busy), .done(done), .label_sums(label_sums), .class_idx(class_idx)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int got_sum(input int k);
        logic signed [SUM_W-1:0] s;
        s = $signed(label_sums[k*SUM_W +: SUM_W]);
        return int'(s);
    endfunction

    function automatic exp_t model(input logic [N*ACT_W-1:0] a, input logic [N-1:0] w);
        exp_t e;
        int s [4];
        int best;
        for (int k = 0; k < 4; k++) s[k] = 0;
        for (int r = 0; r < ROWS; r++) begin
            for (int c = 0; c < COLS; c++) begin
                int el, lab, v;
                el  = r * COLS + c;
                lab = (r % 2) * 2 + (c % 2);
                v   = int'(a[el*ACT_W +: ACT_W]);
                s[lab] += w[el] ? v : -v;
            end
        end
        best = 0;
        for (int k = 1; k < 4; k++) if (s[k] > s[best]) best = k;
        e = '0;
        for (int k = 0; k < 4; k++) e.sums[k] = s[k];
        e.cls = 2'(best);
        return e;
    endfunction

    task automatic run_case(input string req, input bit poke_busy);
        exp_t e;
        @(negedge clk);
        act_plane = act_v;
        wgt_plane = wgt_v;
        start = 1'b1;
        e = model(act_v, wgt_v);
        e.due = cyc + 6;
        sb_q.push_back(e);
        tag_q.push_back(req);
        @(negedge clk);
        start = 1'b0;
        check(busy == 1'b1, "R8", "busy after accept", int'(busy), 1);
        if (poke_busy) begin
            // R5: scrambled planes and an extra start while busy
            act_plane = ~act_v;
            wgt_plane = ~wgt_v;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        while (busy) @(negedge clk);
        repeat (3) @(negedge clk);
        for (int k = 0; k < 4; k++)
            check(got_sum(k) == int'($signed(e.sums[k])), "R6", "held score",
                  got_sum(k), int'($signed(e.sums[k])));
        check(class_idx == e.cls, "R6", "held class", int'(class_idx), int'(e.cls));
        check(busy == 1'b0 && done == 1'b0, "R5", "no extra run", int'(busy), 0);
    endtask

    // monitor: pops the scoreboard whenever a result is published
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (sb_q.size() == 0) begin
                check(1'b0, "R4", "done without pending start", 1, 0);
            end else begin
                exp_t e;
                string t;
                e = sb_q.pop_front();
                t = tag_q.pop_front();
                check(cyc == int'(e.due), "R4", "done cycle", cyc, int'(e.due));
                for (int k = 0; k < 4; k++)
                    check(got_sum(k) == int'($signed(e.sums[k])), t, "label score",
                          got_sum(k), int'($signed(e.sums[k])));
                check(class_idx == e.cls, "R3", "class index", int'(class_idx), int'(e.cls));
            end
        end
    end

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        n_chk++;
        $display("FAIL R4 watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R6 reset state
        check(busy == 1'b0, "R6", "reset busy", int'(busy), 0);
        check(done == 1'b0, "R6", "reset done", int'(done), 0);
        check(class_idx == 2'd0, "R6", "reset class", int'(class_idx), 0);
        for (int k = 0; k < 4; k++)
            check(got_sum(k) == 0, "R6", "reset score", got_sum(k), 0);

        // R1: single element at row 0 col 1 (label 1), weight -1 then +1
        act_v = '0; wgt_v = '0;
        act_v[1*ACT_W +: ACT_W] = 8'd5;
        run_case("R1", 1'b0);
        wgt_v[1] = 1'b1;
        run_case("R1", 1'b0);

        // R2: single element at row 1 col 0 (element 8, label 2)
        act_v = '0; wgt_v = '0;
        act_v[8*ACT_W +: ACT_W] = 8'd9;
        wgt_v[8] = 1'b1;
        run_case("R2", 1'b0);

        // R3: all zero -> full tie, label 0 wins
        act_v = '0; wgt_v = '1;
        run_case("R3", 1'b0);

        // R3: labels 1 and 3 tie at the top -> label 1
        for (int e = 0; e < N; e++) begin
            act_v[e*ACT_W +: ACT_W] = 8'd10;
            wgt_v[e] = ((e % COLS) % 2 == 1);
        end
        run_case("R3", 1'b0);

        // R3: only label 3 positive
        for (int e = 0; e < N; e++)
            wgt_v[e] = ((e / COLS) % 2 == 1) && ((e % COLS) % 2 == 1);
        run_case("R3", 1'b0);

        // R7: extremes
        for (int e = 0; e < N; e++) act_v[e*ACT_W +: ACT_W] = ACT_W'(AMAX);
        wgt_v = '1;
        run_case("R7", 1'b0);
        wgt_v = '0;
        run_case("R7", 1'b0);

        // R5: random planes with start and plane changes while busy
        for (int t = 0; t < 3; t++) begin
            for (int e = 0; e < N; e++) begin
                act_v[e*ACT_W +: ACT_W] = ACT_W'($urandom_range(0, AMAX));
                wgt_v[e] = 1'($urandom_range(0, 1));
            end
            run_case("R5", 1'b1);
        end

        // R2: random planes, back-to-back
        for (int t = 0; t < 6; t++) begin
            for (int e = 0; e < N; e++) begin
                act_v[e*ACT_W +: ACT_W] = ACT_W'($urandom_range(0, AMAX));
                wgt_v[e] = 1'($urandom_range(0, 1));
            end
            run_case("R2", 1'b0);
        end

        repeat (4) @(negedge clk);
        check(sb_q.size() == 0, "R4", "every start produced one result", sb_q.size(), 0);
        finish_run();
    end
endmodule